// File: doc/BRIEF.md
# Two-Channel Power Start Sequencer and Fault Supervisor

This block decides when the auxiliary converter channel and the main converter channel of an isolated supply may switch. Its inputs are digital flags that analog comparators elsewhere produce: the supply has passed its lockout level, the reference is healthy, the input line is above its undervoltage level, the input line is over its overvoltage level, the bootstrapped rail is above the chip supply, the bootstrapped rail has fallen below the restart level, and one output-undervoltage flag for each channel. An enable pin and a polarity-select pin are decoded into a single enable.

The auxiliary channel starts first. The main channel follows once the bootstrapped rail is above the chip supply. An input-side fault stops both channels and holds them stopped until the fault is gone and the bootstrapped rail has collapsed. A cycle counter measures how long either output-undervoltage flag stays set. When it runs the full timeout, a fault latches that only a deliberate toggle of the enable pin or the line-undervoltage flag can clear, and only while both flags are clear and the bootstrapped rail is low. A soft-start discharge request stays asserted for as long as the auxiliary channel is stopped.

The state machine has five states. IDLE is the reset state. AUX_ON has only the auxiliary channel running. BOTH_ON has both channels running. IN_FAULT waits after an input-side fault. TMR_LATCH is the latched undervoltage-timer fault. Its transitions are:

- go_aux (IDLE to AUX_ON)
- go_both (AUX_ON to BOTH_ON)
- trip (AUX_ON or BOTH_ON to IN_FAULT)
- restart (IN_FAULT to AUX_ON)
- timeout (AUX_ON, BOTH_ON or IN_FAULT to TMR_LATCH)
- rearm (TMR_LATCH to IDLE)

Top module: `pwr_seq_supervisor`

## Requirements
- R1: The decoded enable is true when `pol_sel` is 1 and `en_pin` is 0, or when `pol_sel` is 0 and `en_pin` is 1.
- R2: The go condition is `vcc_ok & ref_ok & line_uv_ok & !line_ov & enable`. If it is false while a channel runs, both run outputs drop at the next edge, and the state becomes IN_FAULT with `fault_code` = 2'b01.
- R3: `run_aux` asserts from IDLE one edge after the go condition is true; it stays low while `vcc_ok` is 0.
- R4: `run_main` asserts one edge after `boot_gt_vcc` is seen with `run_aux` high, and never while `run_aux` is low.
- R5: `run_main` falls at the same edge as `run_aux`.
- R6: From IN_FAULT the auxiliary channel restarts only at an edge where the go condition and `boot_low` are both true; with `boot_low` at 0 it stays stopped.
- R7: If `ouv_aux | ouv_main` is sampled high on TIMEOUT consecutive edges while in AUX_ON, BOTH_ON or IN_FAULT, the state becomes TMR_LATCH at the TIMEOUT-th edge: both runs are low and `fault_code` = 2'b10.
- R8: The timer returns to zero on any edge where both undervoltage flags are low, so a run of TIMEOUT-1 cycles followed by a clear cycle trips nothing.
- R9: TMR_LATCH is left, to IDLE with `fault_code` = 2'b00, only at an edge where both undervoltage flags are 0, `boot_low` is 1, and `en_pin` or `line_uv_ok` differs from its value at the previous edge.
- R10: `ss_discharge` is 1 exactly when `run_aux` is 0.
- R11: When a timer expiry and an input fault arrive at the same edge, TMR_LATCH wins.
- R12: After reset the outputs are `run_aux`=0, `run_main`=0, `ss_discharge`=1, `fault_code`=2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| vcc_ok | input | 1 | Chip supply above lockout level |
| ref_ok | input | 1 | Reference healthy |
| line_uv_ok | input | 1 | Input line above undervoltage level |
| line_ov | input | 1 | Input line above overvoltage level |
| boot_gt_vcc | input | 1 | Bootstrapped rail above chip supply |
| boot_low | input | 1 | Bootstrapped rail below restart level |
| ouv_aux | input | 1 | Auxiliary output undervoltage flag |
| ouv_main | input | 1 | Main output undervoltage flag |
| en_pin | input | 1 | Enable pin |
| pol_sel | input | 1 | Enable polarity select |
| run_aux | output | 1 | Auxiliary channel may switch |
| run_main | output | 1 | Main channel may switch |
| ss_discharge | output | 1 | Soft-start discharge request |
| fault_code | output | 2 | 00 none, 01 input fault, 10 timer latch |

## Verification
The assertions assume that every input flag is already synchronous to `clk`, so each flag holds one value per sampled edge. They also assume that the reset value of the toggle-history registers, which is 0, does not count as a toggle, because TMR_LATCH cannot be reached in the first cycles after reset. The stimulus changes inputs only just after a falling edge and keeps each level for whole cycles. Undervoltage flags are raised only after the channels are running, and the toggles that exit TMR_LATCH are single deliberate pin changes.

// File: rtl/sup_pkg.sv
package sup_pkg;
    typedef enum logic [2:0] {
        IDLE      = 3'd0,
        AUX_ON    = 3'd1,
        BOTH_ON   = 3'd2,
        IN_FAULT  = 3'd3,
        TMR_LATCH = 3'd4
    } sup_state_t;

    localparam logic [1:0] FLT_NONE  = 2'b00;
    localparam logic [1:0] FLT_INPUT = 2'b01;
    localparam logic [1:0] FLT_TIMER = 2'b10;
endpackage

// File: rtl/sup_gate_qual.sv
module sup_gate_qual (
    input  logic clk,
    input  logic rst_n,
    input  logic vcc_ok,
    input  logic ref_ok,
    input  logic line_uv_ok,
    input  logic line_ov,
    input  logic en_pin,
    input  logic pol_sel,
    output logic go_ok,
    output logic toggled
);
    logic en_q;
    logic uv_q;
    logic enable;

    // polarity select: high select means the enable pin is active low
    assign enable = pol_sel ? ~en_pin : en_pin;
    assign go_ok  = vcc_ok & ref_ok & line_uv_ok & ~line_ov & enable;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q <= 1'b0;
            uv_q <= 1'b0;
        end else begin
            en_q <= en_pin;
            uv_q <= line_uv_ok;
        end
    end

    assign toggled = (en_pin ^ en_q) | (line_uv_ok ^ uv_q);
endmodule

// File: rtl/sup_ouv_timer.sv
module sup_ouv_timer #(
    parameter int TIMEOUT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic count_en,
    input  logic flag_any,
    output logic expire
);
    localparam int CW = $clog2(TIMEOUT + 1);
    localparam logic [CW-1:0] LAST = CW'(TIMEOUT - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (count_en && flag_any && cnt != LAST)
            cnt <= cnt + 1'b1;
        else
            cnt <= '0;
    end

    assign expire = count_en & flag_any & (cnt == LAST);
endmodule

// File: rtl/pwr_seq_supervisor.sv
module pwr_seq_supervisor
    import sup_pkg::*;
#(
    parameter int TIMEOUT = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       vcc_ok,
    input  logic       ref_ok,
    input  logic       line_uv_ok,
    input  logic       line_ov,
    input  logic       boot_gt_vcc,
    input  logic       boot_low,
    input  logic       ouv_aux,
    input  logic       ouv_main,
    input  logic       en_pin,
    input  logic       pol_sel,
    output logic       run_aux,
    output logic       run_main,
    output logic       ss_discharge,
    output logic [1:0] fault_code
);
    sup_state_t state, state_nx;
    logic go_ok, toggled, expire, tmr_en, flag_any;

    sup_gate_qual u_qual (
        .clk(clk), .rst_n(rst_n), .vcc_ok(vcc_ok), .ref_ok(ref_ok),
        .line_uv_ok(line_uv_ok), .line_ov(line_ov), .en_pin(en_pin),
        .pol_sel(pol_sel), .go_ok(go_ok), .toggled(toggled)
    );

    assign flag_any = ouv_aux | ouv_main;
    assign tmr_en   = (state == AUX_ON) || (state == BOTH_ON) || (state == IN_FAULT);

    sup_ouv_timer #(.TIMEOUT(TIMEOUT)) u_tmr (
        .clk(clk), .rst_n(rst_n), .count_en(tmr_en),
        .flag_any(flag_any), .expire(expire)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            IDLE:      if (go_ok) state_nx = AUX_ON;
            AUX_ON: begin
                if (expire)           state_nx = TMR_LATCH;
                else if (!go_ok)      state_nx = IN_FAULT;
                else if (boot_gt_vcc) state_nx = BOTH_ON;
            end
            BOTH_ON: begin
                if (expire)      state_nx = TMR_LATCH;
                else if (!go_ok) state_nx = IN_FAULT;
            end
            IN_FAULT: begin
                if (expire)                state_nx = TMR_LATCH;
                else if (go_ok && boot_low) state_nx = AUX_ON;
            end
            TMR_LATCH:
                if (!flag_any && boot_low && toggled) state_nx = IDLE;
            default:   state_nx = IDLE;
        endcase
    end

    always_comb begin
        run_aux    = 1'b0;
        run_main   = 1'b0;
        fault_code = FLT_NONE;
        unique case (state)
            IDLE:      ;
            AUX_ON:    run_aux = 1'b1;
            BOTH_ON: begin
                run_aux  = 1'b1;
                run_main = 1'b1;
            end
            IN_FAULT:  fault_code = FLT_INPUT;
            TMR_LATCH: fault_code = FLT_TIMER;
            default:   ;
        endcase
        ss_discharge = ~run_aux;
    end
endmodule

// File: rtl/pwr_seq_supervisor_chk.sv
module pwr_seq_supervisor_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       vcc_ok,
    input logic       ref_ok,
    input logic       line_uv_ok,
    input logic       line_ov,
    input logic       boot_gt_vcc,
    input logic       boot_low,
    input logic       en_pin,
    input logic       run_aux,
    input logic       run_main,
    input logic       ss_discharge,
    input logic [1:0] fault_code
);
    // R4
    main_needs_aux_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run_main |-> run_aux);

    // R4
    main_start_cond_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run_main) |-> $past(boot_gt_vcc) && $past(run_aux));

    // R3
    aux_start_cond_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run_aux) |-> $past(vcc_ok) && $past(ref_ok));

    // R2
    ov_stops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_aux && line_ov) |=> !run_aux);

    // R6
    restart_interlock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(run_aux) && $past(fault_code) == 2'b01) |-> $past(boot_low));

    // R9
    latch_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_code == 2'b10 && $past(fault_code) == 2'b10 &&
         en_pin == $past(en_pin) && line_uv_ok == $past(line_uv_ok))
        |=> fault_code == 2'b10);

    // R10
    ss_tracks_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(run_aux) |-> ss_discharge);

    // R7
    latch_stops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_code == 2'b10) |-> !run_aux && !run_main);
endmodule

bind pwr_seq_supervisor pwr_seq_supervisor_chk u_chk (.*);

// File: tb/tb_pwr_seq_supervisor.sv
module tb_pwr_seq_supervisor;
    localparam int TMO = 8;
    localparam logic [4:0] E_IDLE = 5'b00100;
    localparam logic [4:0] E_AUX  = 5'b10000;
    localparam logic [4:0] E_BOTH = 5'b11000;
    localparam logic [4:0] E_FLT  = 5'b00101;
    localparam logic [4:0] E_LAT  = 5'b00110;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic vcc_ok, ref_ok, line_uv_ok, line_ov, boot_gt_vcc, boot_low;
    logic ouv_aux, ouv_main, en_pin, pol_sel;
    logic run_aux, run_main, ss_discharge;
    logic [1:0] fault_code;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [4:0] q_exp[$];
    string      q_tag[$];

    always #10 clk = ~clk;

    pwr_seq_supervisor #(.TIMEOUT(TMO)) dut (
        .clk(clk), .rst_n(rst_n), .vcc_ok(vcc_ok), .ref_ok(ref_ok),
        .line_uv_ok(line_uv_ok), .line_ov(line_ov), .boot_gt_vcc(boot_gt_vcc),
        .boot_low(boot_low), .ouv_aux(ouv_aux), .ouv_main(ouv_main),
        .en_pin(en_pin), .pol_sel(pol_sel), .run_aux(run_aux),
        .run_main(run_main), .ss_discharge(ss_discharge), .fault_code(fault_code)
    );

    // monitor: compare the observed outputs with the queued expectation
    always @(negedge clk) begin
        if (q_exp.size() > 0) begin
            logic [4:0] e, a;
            string t;
            e = q_exp.pop_front();
            t = q_tag.pop_front();
            a = {run_aux, run_main, ss_discharge, fault_code};
            checks++;
            if (a !== e) begin
                errors++;
                $display("FAIL %s: got %b expected %b", t, a, e);
            end else if (a[4] == a[2]) begin
                checks++;
            end
            if (a[2] !== ~a[4]) begin
                errors++;
                $display("FAIL R10: ss %b run_aux %b", a[2], a[4]);
            end
        end
    end

    // driver: one clock edge, then queue the state expected after it
    task automatic step(input logic [4:0] e, input string tag);
        @(posedge clk);
        #1;
        q_exp.push_back(e);
        q_tag.push_back(tag);
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #2000000;
        errors++;
        $display("FAIL watchdog: run did not end, expected completion");
        finish_run();
    end

    initial begin
        vcc_ok = 0; ref_ok = 1; line_uv_ok = 1; line_ov = 0;
        boot_gt_vcc = 0; boot_low = 1; ouv_aux = 0; ouv_main = 0;
        pol_sel = 1; en_pin = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        step(E_IDLE, "R12 reset state");
        step(E_IDLE, "R3 lockout holds idle");
        vcc_ok = 1;
        step(E_AUX, "R3 aux starts");
        step(E_AUX, "R4 main waits for boot rail");
        boot_gt_vcc = 1;
        step(E_BOTH, "R4 main starts");
        line_ov = 1;
        step(E_FLT, "R2 R5 overvoltage trip");
        line_ov = 0; boot_low = 0;
        step(E_FLT, "R6 restart blocked");
        step(E_FLT, "R6 restart blocked");
        boot_low = 1;
        step(E_AUX, "R6 restart");
        step(E_BOTH, "R4 main after restart");
        // polarity
        en_pin = 1;
        step(E_FLT, "R1 high select, pin high disables");
        pol_sel = 0;
        step(E_AUX, "R1 low select, pin high enables");
        step(E_BOTH, "R1 running");
        en_pin = 0;
        step(E_FLT, "R1 low select, pin low disables");
        en_pin = 1;
        step(E_AUX, "R1 re-enabled");
        step(E_BOTH, "R1 running");
        ref_ok = 0;
        step(E_FLT, "R2 reference fault");
        ref_ok = 1;
        step(E_AUX, "R2 recovered");
        step(E_BOTH, "R2 running");
        // near miss then clear
        ouv_aux = 1;
        for (int i = 0; i < TMO - 1; i++) step(E_BOTH, "R8 below timeout");
        ouv_aux = 0;
        step(E_BOTH, "R8 clear resets timer");
        ouv_main = 1;
        for (int i = 0; i < TMO - 1; i++) step(E_BOTH, "R7 counting");
        step(E_LAT, "R7 timer latch");
        // latch exit conditions
        step(E_LAT, "R9 no toggle holds");
        en_pin = 0;
        step(E_LAT, "R9 toggle with flag set holds");
        en_pin = 1;
        step(E_LAT, "R9 toggle with flag set holds");
        ouv_main = 0; boot_low = 0; en_pin = 0;
        step(E_LAT, "R9 toggle with boot high holds");
        step(E_LAT, "R9 no toggle holds");
        boot_low = 1;
        step(E_LAT, "R9 no toggle holds");
        en_pin = 1;
        step(E_IDLE, "R9 enable toggle rearms");
        step(E_AUX, "R3 start after rearm");
        step(E_BOTH, "R4 main after rearm");
        // priority of expiry over input fault
        ouv_aux = 1;
        for (int i = 0; i < TMO - 1; i++) step(E_BOTH, "R11 counting");
        line_ov = 1;
        step(E_LAT, "R11 timer wins over input fault");
        line_ov = 0; ouv_aux = 0;
        line_uv_ok = 0;
        step(E_IDLE, "R9 line flag toggle rearms");
        step(E_IDLE, "R2 line undervoltage keeps idle");
        line_uv_ok = 1;
        step(E_AUX, "R3 start");
        @(negedge clk);
        finish_run();
    end
endmodule